// File: doc/BRIEF.md
# Light-Load Pulse-Frequency Controller with Current-Direction Inference

This block drives the two gates of a bidirectional synchronous buck/boost power stage while the stage runs at light load. Every pulse has a fixed shape. One switch conducts for a fixed on-time unit. The gates then rest for one idle clock. The complementary switch conducts for the same unit. Both gates then stay off until the period ends, so the body diode can bring the inductor current back to zero. The controller regulates the low-side voltage by changing only the pulse repetition period.

Two digital flags tell the controller where the inductor current is. One pulses when the current crosses zero going forward and the other when it crosses going in reverse. The controller watches them over an observation window of a fixed number of pulses. If at most one flag changed, the pulse direction is taken as correct, and the controller moves the period according to two voltage flags, "low-side too low" and "low-side too high". The sign of that rule depends on whether the stage is running in buck or boost direction. If both flags changed, the current is swinging across zero. The controller then lengthens the period and does no voltage regulation. If the period is already at its ceiling, it reverses the pulse direction, restarts from a mid-range period and lets some settling pulses pass before it observes again.

The sequencer has three states. ST_IDLE holds the gates off. ST_SETTLE emits pulses without judging them. ST_OBSERVE judges each window. The transitions are:
- enable rising: ST_IDLE to ST_SETTLE
- settle count done: ST_SETTLE to ST_OBSERVE
- window end with regulation or back-off: ST_OBSERVE to ST_OBSERVE
- window end with reversal: ST_OBSERVE to ST_SETTLE
- enable low, from any state: to ST_IDLE

Top module: `pfm_dir_ctrl`

## Requirements
- R1: Each pulse is shaped as follows.
  - The leading gate is high for DT clocks (default 4).
  - Both gates are then low for exactly one clock.
  - The trailing gate is high for DT clocks.
  - Both gates stay low for the rest of the period.
  - The two gates are never high in the same cycle.
- R2: With dir_boost = 0 (buck), gate_hs leads each pulse. With dir_boost = 1 (boost), gate_ls leads.
- R3: In buck direction, a window ends with at most one detect flag having changed. Then:
  - vlo_low = 1 and vlo_high = 0 shortens the period by STEP (default 8).
  - vlo_high = 1 and vlo_low = 0 lengthens it by STEP.
  - Both flags set, or neither set, leaves the period unchanged.
- R4: In boost direction the same window outcome uses the reverse rule. vlo_low alone lengthens the period by STEP, and vlo_high alone shortens it by STEP.
- R5: A window in which both fwd_det and rev_det changed lengthens the period by STEP when the period is below its maximum, whatever the voltage flags say.
- R6: A window in which both flags changed, ending while the period equals its maximum (default 64), inverts dir_boost. The period is reset to the mid value (default 40). SETTLE_PULSES pulses (default 1) are emitted before the next window starts.
- R7: The period is kept between the larger of T_MIN and 2*DT+1+DEAD_MARGIN (default 16) and T_MAX (default 64). A step that would cross either bound stops at that bound.
- R8: While en is low, both gates stay low and dir_boost keeps its value. The next rise of en starts with SETTLE_PULSES pulses at the mid period.
- R9: After reset, both gates are low, dir_boost is 0 and the first pulse after enabling has the mid period.
- R10: The period changes only at a pulse boundary. Each observation window spans WIN_PULSES pulses (default 2) and is followed directly by the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Light-load operation enable |
| fwd_det | input | 1 | Forward zero-crossing detect flag |
| rev_det | input | 1 | Reverse zero-crossing detect flag |
| vlo_low | input | 1 | Low-side voltage below target |
| vlo_high | input | 1 | Low-side voltage above target |
| gate_hs | output | 1 | High-side switch gate |
| gate_ls | output | 1 | Low-side switch gate |
| dir_boost | output | 1 | Current pulse direction, 1 = boost |

## Verification
The following properties are checked on every cycle:
- the gates are never high together, and each hand-off has an idle clock between them;
- the period stays inside its bounds and changes only at a pulse boundary;
- a direction reversal happens only from the maximum period after a window in which both flags changed;
- a window with no swing never reports one.

The bench scenarios are what show that the regulation law has the right sign in each direction. They also show:
- that back-off overrides the voltage flags;
- the number of pulses in a window and in settling;
- the exact period after each decision;
- the return to mid period on re-enable.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_OBSERVE = 2'd2
    } pfm_state_t;

    typedef enum logic {
        DIR_BUCK  = 1'b0,
        DIR_BOOST = 1'b1
    } pfm_dir_t;

endpackage

// File: rtl/pfm_pulse_gen.sv
module pfm_pulse_gen
    import pfm_pkg::*;
#(
    parameter int DT    = 4,
    parameter int PW    = 8,
    parameter int FLOOR = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period,
    input  pfm_dir_t      dir,
    output logic          gate_hs,
    output logic          gate_ls,
    output logic          pulse_end
);

    localparam logic [PW-1:0] PH_LEAD  = PW'(DT);
    localparam logic [PW-1:0] PH_TRAIL = PW'(2 * DT);
    localparam logic [PW-1:0] P_FLOOR  = PW'(FLOOR);

    logic [PW-1:0] cnt;
    logic          lead_on;
    logic          trail_on;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (pulse_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PW'(1);
        end
    end

    always_comb begin
        pulse_end = run && (cnt >= period - PW'(1));
        lead_on   = run && (cnt < PH_LEAD);
        trail_on  = run && (cnt > PH_LEAD) && (cnt <= PH_TRAIL);
        if (dir == DIR_BUCK) begin
            gate_hs = lead_on;
            gate_ls = trail_on;
        end else begin
            gate_hs = trail_on;
            gate_ls = lead_on;
        end
    end

    // R1
    gates_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs && gate_ls));

    // R1
    ls_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ls) |-> !$past(gate_hs));

    // R1
    hs_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hs) |-> !$past(gate_ls));

    // R7
    period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (period >= P_FLOOR));

endmodule

// File: rtl/pfm_slosh_det.sv
module pfm_slosh_det (
    input  logic clk,
    input  logic rst_n,
    input  logic fwd,
    input  logic rev,
    input  logic clr,
    output logic both_seen
);

    logic fwd_prev;
    logic rev_prev;
    logic fwd_seen;
    logic rev_seen;
    logic fwd_tog;
    logic rev_tog;

    always_comb begin
        fwd_tog   = fwd ^ fwd_prev;
        rev_tog   = rev ^ rev_prev;
        both_seen = (fwd_seen | fwd_tog) & (rev_seen | rev_tog);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_prev <= 1'b0;
            rev_prev <= 1'b0;
            fwd_seen <= 1'b0;
            rev_seen <= 1'b0;
        end else begin
            fwd_prev <= fwd;
            rev_prev <= rev;
            fwd_seen <= clr ? 1'b0 : (fwd_seen | fwd_tog);
            rev_seen <= clr ? 1'b0 : (rev_seen | rev_tog);
        end
    end

    // R5
    quiet_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && ($stable(fwd) || $stable(rev))) |-> !both_seen);

endmodule

// File: rtl/pfm_seq_ctrl.sv
module pfm_seq_ctrl
    import pfm_pkg::*;
#(
    parameter int PW     = 8,
    parameter int T_LO   = 16,
    parameter int T_HI   = 64,
    parameter int T_MID  = 40,
    parameter int STEP   = 8,
    parameter int WIN    = 2,
    parameter int SETTLE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pulse_end,
    input  logic          both_seen,
    input  logic          vlo_low,
    input  logic          vlo_high,
    output logic          run,
    output logic          clr,
    output logic [PW-1:0] period,
    output pfm_dir_t      dir
);

    localparam int CMAX = (WIN > SETTLE) ? WIN : SETTLE;
    localparam int CW   = $clog2(CMAX + 1);

    localparam logic [PW-1:0] P_LO   = PW'(T_LO);
    localparam logic [PW-1:0] P_HI   = PW'(T_HI);
    localparam logic [PW-1:0] P_MID  = PW'(T_MID);
    localparam logic [PW-1:0] P_STEP = PW'(STEP);
    localparam logic [PW:0]   W_STEP = (PW+1)'(STEP);
    localparam logic [CW-1:0] C_WIN  = CW'(WIN - 1);
    localparam logic [CW-1:0] C_SET  = CW'(SETTLE - 1);

    pfm_state_t    state_q, state_d;
    logic [PW-1:0] period_q, period_d;
    pfm_dir_t      dir_q, dir_d;
    logic [CW-1:0] pcnt_q, pcnt_d;

    logic          win_end;
    logic [PW:0]   up_w;
    logic [PW-1:0] per_up;
    logic [PW-1:0] per_dn;
    logic          go_fast;
    logic          go_slow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            period_q <= P_MID;
            dir_q    <= DIR_BUCK;
            pcnt_q   <= '0;
        end else begin
            state_q  <= state_d;
            period_q <= period_d;
            dir_q    <= dir_d;
            pcnt_q   <= pcnt_d;
        end
    end

    always_comb begin
        up_w   = {1'b0, period_q} + W_STEP;
        per_up = (up_w > {1'b0, P_HI}) ? P_HI : up_w[PW-1:0];
        per_dn = ({1'b0, period_q} < ({1'b0, P_LO} + W_STEP)) ? P_LO : (period_q - P_STEP);
        if (dir_q == DIR_BUCK) begin
            go_fast = vlo_low && !vlo_high;
            go_slow = vlo_high && !vlo_low;
        end else begin
            go_fast = vlo_high && !vlo_low;
            go_slow = vlo_low && !vlo_high;
        end
        win_end = (state_q == ST_OBSERVE) && pulse_end && (pcnt_q == C_WIN);
    end

    always_comb begin
        state_d  = state_q;
        period_d = period_q;
        dir_d    = dir_q;
        pcnt_d   = pcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                pcnt_d = '0;
                if (en) begin
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (pulse_end) begin
                    if (pcnt_q == C_SET) begin
                        state_d = ST_OBSERVE;
                        pcnt_d  = '0;
                    end else begin
                        pcnt_d = pcnt_q + CW'(1);
                    end
                end
            end
            ST_OBSERVE: begin
                if (win_end) begin
                    pcnt_d = '0;
                    if (both_seen) begin
                        if (period_q >= P_HI) begin
                            dir_d    = (dir_q == DIR_BUCK) ? DIR_BOOST : DIR_BUCK;
                            period_d = P_MID;
                            state_d  = ST_SETTLE;
                        end else begin
                            period_d = per_up;
                        end
                    end else if (go_fast) begin
                        period_d = per_dn;
                    end else if (go_slow) begin
                        period_d = per_up;
                    end
                end else if (pulse_end) begin
                    pcnt_d = pcnt_q + CW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en) begin
            state_d  = ST_IDLE;
            period_d = P_MID;
            pcnt_d   = '0;
        end
    end

    always_comb begin
        run    = (state_q != ST_IDLE);
        clr    = (state_q != ST_OBSERVE) || win_end;
        period = period_q;
        dir    = dir_q;
    end

    // R7
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q >= P_LO) && (period_q <= P_HI));

    // R10
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && en && !pulse_end) |=> $stable(period_q));

    // R6
    dir_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_q) |-> (($past(period_q) == P_HI) && $past(both_seen) && $past(en)));

    // R5
    backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && en && both_seen && (period_q < P_HI)) |=>
            ((period_q > $past(period_q)) && $stable(dir_q)));

endmodule

// File: rtl/pfm_dir_ctrl.sv
module pfm_dir_ctrl
    import pfm_pkg::*;
#(
    parameter int DT            = 4,
    parameter int DEAD_MARGIN   = 2,
    parameter int T_MIN         = 16,
    parameter int T_MAX         = 64,
    parameter int STEP          = 8,
    parameter int WIN_PULSES    = 2,
    parameter int SETTLE_PULSES = 1,
    parameter int PW            = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fwd_det,
    input  logic rev_det,
    input  logic vlo_low,
    input  logic vlo_high,
    output logic gate_hs,
    output logic gate_ls,
    output logic dir_boost
);

    localparam int FLOOR = 2 * DT + 1 + DEAD_MARGIN;
    localparam int T_LO  = (T_MIN > FLOOR) ? T_MIN : FLOOR;
    localparam int T_MID = (T_LO + T_MAX) / 2;

    logic          run;
    logic          clr;
    logic          pulse_end;
    logic          both_seen;
    logic [PW-1:0] period;
    pfm_dir_t      dir;

    pfm_seq_ctrl #(
        .PW(PW), .T_LO(T_LO), .T_HI(T_MAX), .T_MID(T_MID),
        .STEP(STEP), .WIN(WIN_PULSES), .SETTLE(SETTLE_PULSES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .pulse_end(pulse_end),
        .both_seen(both_seen), .vlo_low(vlo_low), .vlo_high(vlo_high),
        .run(run), .clr(clr), .period(period), .dir(dir)
    );

    pfm_slosh_det u_det (
        .clk(clk), .rst_n(rst_n), .fwd(fwd_det), .rev(rev_det),
        .clr(clr), .both_seen(both_seen)
    );

    pfm_pulse_gen #(.DT(DT), .PW(PW), .FLOOR(FLOOR)) u_pg (
        .clk(clk), .rst_n(rst_n), .run(run), .period(period), .dir(dir),
        .gate_hs(gate_hs), .gate_ls(gate_ls), .pulse_end(pulse_end)
    );

    assign dir_boost = (dir == DIR_BOOST);

endmodule

// File: tb/sim_pfm_dir_ctrl.sv
module sim_pfm_dir_ctrl;

    localparam int DT   = 4;
    localparam int TMID = 40;
    localparam int NV   = 22;

    // vector: fwd toggles, rev toggles, vlo_low, vlo_high, flip expected, dir after, period after
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd32},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd24},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd16},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd16},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd24},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd24},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd24},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd32},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd40},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd48},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd56},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd64},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd40},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd48},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd40},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd32},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd40},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd48},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd56},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd64},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd40},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd48}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic fwd = 1'b0;
    logic rev = 1'b0;
    logic vlo_low = 1'b0;
    logic vlo_high = 1'b0;
    logic gate_hs;
    logic gate_ls;
    logic dir_boost;

    always #4 clk = ~clk;

    pfm_dir_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .fwd_det(fwd), .rev_det(rev),
        .vlo_low(vlo_low), .vlo_high(vlo_high),
        .gate_hs(gate_hs), .gate_ls(gate_ls), .dir_boost(dir_boost)
    );

    int   n_tests = 0;
    int   n_fail = 0;
    int   starts = 0;
    int   cyc = 0;
    int   last_start = 0;
    int   last_len = 0;
    logic last_dir = 1'b0;
    int   idle_run = 100;
    int   off = 0;
    int   hs_w = 0;
    int   ls_w = 0;
    int   shape_err = 0;
    logic prev_hs = 1'b0;
    logic prev_ls = 1'b0;
    logic fm = 1'b0;
    logic rm = 1'b0;
    bit   skip;

    // pulse monitor and detect-flag stimulus, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (gate_hs && gate_ls) shape_err++;
        if (gate_hs && !prev_hs && prev_ls) shape_err++;
        if (gate_ls && !prev_ls && prev_hs) shape_err++;
        if (gate_hs) hs_w++;
        else begin
            if (prev_hs && hs_w != DT) shape_err++;
            hs_w = 0;
        end
        if (gate_ls) ls_w++;
        else begin
            if (prev_ls && ls_w != DT) shape_err++;
            ls_w = 0;
        end
        if ((gate_hs || gate_ls) && !prev_hs && !prev_ls && idle_run >= 2) begin
            last_len   = cyc - last_start;
            last_start = cyc;
            last_dir   = gate_ls;
            off        = 0;
            starts++;
        end else begin
            off++;
        end
        if (gate_hs || gate_ls) idle_run = 0;
        else idle_run++;
        if (off == 2 || off == 6) begin
            if (fm) fwd = ~fwd;
            if (rm) rev = ~rev;
        end
        prev_hs = gate_hs;
        prev_ls = gate_ls;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_start();
        int n;
        n = starts;
        wait (starts != n);
        #1;
    endtask

    task automatic apply(input logic [13:0] v);
        fm       = v[13];
        rm       = v[12];
        vlo_low  = v[11];
        vlo_high = v[10];
    endtask

    function automatic string req_of(input int v);
        if (VEC[v][9]) return "R6";
        if (v == 3 || v == 11) return "R7";
        if (VEC[v][13] && VEC[v][12]) return "R5";
        if (VEC[v][8]) return "R4";
        return "R3";
    endfunction

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bad;
        repeat (5) @(negedge clk);
        // R9 reset state
        check(!gate_hs && !gate_ls, "R9", "gates in reset", {gate_hs, gate_ls}, 0);
        check(dir_boost == 1'b0, "R9", "direction in reset", dir_boost, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!gate_hs && !gate_ls, "R8", "gates idle while disabled", {gate_hs, gate_ls}, 0);

        en = 1'b1;
        wait_start();
        check(last_dir == 1'b0, "R2", "buck leads with high side", last_dir, 0);
        apply(VEC[0]);
        wait_start();
        check(last_len == TMID, "R9", "first settle pulse period", last_len, TMID);

        skip = 1'b0;
        for (int v = 0; v < NV; v++) begin
            if (!skip) wait_start();
            wait_start();
            check(last_dir == VEC[v][8], "R2", $sformatf("leading gate after vector %0d", v),
                  last_dir, VEC[v][8]);
            check(dir_boost == VEC[v][8], req_of(v), $sformatf("dir_boost after vector %0d", v),
                  dir_boost, VEC[v][8]);
            if (v < NV - 1) apply(VEC[v + 1]);
            wait_start();
            check(last_len == int'(VEC[v][7:0]), req_of(v),
                  $sformatf("period after vector %0d (R10)", v), last_len, VEC[v][7:0]);
            skip = !VEC[v][9];
        end

        // R8 disable in the off part of a pulse, then re-enable
        wait_start();
        repeat (2 * DT + 3) @(negedge clk);
        en = 1'b0;
        fm = 1'b0;
        rm = 1'b0;
        vlo_low = 1'b0;
        vlo_high = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (gate_hs || gate_ls) bad++;
        end
        check(bad == 0, "R8", "gate cycles while disabled", bad, 0);
        check(dir_boost == 1'b0, "R8", "direction kept while disabled", dir_boost, 0);
        en = 1'b1;
        wait_start();
        check(last_dir == 1'b0, "R8", "leading gate on re-enable", last_dir, 0);
        wait_start();
        check(last_len == TMID, "R8", "re-enable period is mid value", last_len, TMID);
        wait_start();
        check(last_len == TMID, "R8", "first window period after re-enable", last_len, TMID);

        check(shape_err == 0, "R1", "pulse shape violations", shape_err, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule